// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static RAM. It has a registered read path and a deferred write-data path. The host presents an address and a command on every rising clock edge. Read data leaves an output register one enabled edge after the array is accessed. Write data is taken from the data-in bus two enabled edges after its command. Because of this, a read and a write issued back to back both use the data bus at the same offset from their commands. Commands can therefore alternate every cycle and the bus never needs an idle cycle to turn around.

A two-bit burst counter can stand in for the low address bits on cycles that advance instead of loading. A static input chooses linear or interleaved burst order. Three chip selects, one byte-write enable per 9-bit lane, a clock enable that freezes the whole pipeline, an asynchronous output enable and an asynchronous sleep input complete the control set. Depth and lane count are parameters. The defaults are 64 words of two 9-bit lanes.

The data path has no valid/ready handshake. The timing of the bus is fixed by the command. The host's only means of back-pressure is to drop `cken`: that edge is then ignored and all commands in flight wait. The bidirectional data bus is split into `wdata` and `rdata`. `rdata_en` tells when the output drivers would be on, and `rdata` reads zero while they are off.

Top module: `nt_sram`

## Requirements
- R1: A read command captured at enabled edge k makes `rdata_en` high and `rdata` equal to the word at its address after enabled edge k+1, provided `oe` is high and `sleep` is low. The output holds until the next enabled edge.
- R2: A write command captured at enabled edge k takes its data from `wdata` at enabled edge k+2. It uses the address and byte enables captured at edge k.
- R3: `byte_we[l]` high lets a write update bits [9l+8:9l]. A lane whose enable is low keeps its old contents.
- R4: With `cken` low, the edge is ignored. Commands and `wdata` are not captured, and the pipeline and the output hold. The two-edge write-data delay counts enabled edges only.
- R5: A load cycle selects the device only when `sel_a`=1, `sel_b`=1 and `sel_c_n`=0. Any other combination is a deselect: nothing is written, and one enabled edge later `rdata_en` is low.
- R6: With `adv`=1, the cycle repeats the operation of the last load cycle (read, write or deselect) and steps the burst counter. The upper address bits stay those of the load. On these cycles the selects, `wr` and `addr` are ignored, while `byte_we` is still sampled. After reset, the repeated operation is a deselect.
- R7: On the n-th advance after a load with low address bits s, the low address bits are (s+n) mod 4 when `linear_order`=1, and s XOR (n mod 4) when `linear_order`=0.
- R8: `oe` low forces `rdata_en` low and `rdata` to zero at once, with no clock edge needed. It does not disturb the pipeline.
- R9: `sleep` high turns the outputs off at once and makes clock edges count as disabled. Memory contents and pending commands are kept.
- R10: A read captured one enabled edge after a write to the same address returns that write's data in the enabled lanes, and the older contents in the other lanes.
- R11: After reset, `rdata_en` is low and no command is pending.
- R12: Read and write commands may alternate on consecutive enabled edges with no idle cycle, and every read returns the correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| cken | input | 1 | Clock enable; low ignores the edge |
| sel_a | input | 1 | Chip select, active high |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| wr | input | 1 | 1 write, 0 read, on load cycles |
| adv | input | 1 | 1 advance burst, 0 load new address |
| byte_we | input | LANES | Per-lane write enable |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data, sampled two enabled edges after its command |
| linear_order | input | 1 | Static burst order: 1 linear, 0 interleaved |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Asynchronous power-down |
| rdata | output | LANES*LANE_W | Read data, zero while not driven |
| rdata_en | output | 1 | Output drivers on |

## Verification
The hardest case to reach from the ports is a read that lands in the cycle where an older write to the same word is still waiting for its data. In that cycle the array holds stale data and the merged value exists only on the bypass path. The bench reaches it by issuing each write immediately followed by a read of the same address, for every byte-enable pattern. It also alternates writes and reads across the whole array, and it inserts clock-enable stalls, with deliberately wrong data on the bus, while a write's data is still pending. Bursts are swept over every seed and both orders, including the wrap past the fourth beat.

// File: rtl/nts_pkg.sv
package nts_pkg;
  localparam int BURST_BITS = 2;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Low address bits of a burst beat from its seed and beat count.
  function automatic logic [BURST_BITS-1:0] burst_low(
    input logic [BURST_BITS-1:0] seed,
    input logic [BURST_BITS-1:0] beat,
    input logic                  linear
  );
    return linear ? (seed + beat) : (seed ^ beat);
  endfunction
endpackage

// File: rtl/nts_burst.sv
module nts_burst
  import nts_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              selected,
  input  logic              adv,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              linear_order,
  output op_e               cyc_op,
  output logic [ADDR_W-1:0] cyc_addr
);
  logic [ADDR_W-1:0]     base_q;
  logic [BURST_BITS-1:0] beat_q;
  logic [BURST_BITS-1:0] beat_nxt;
  op_e                   op_q;

  assign beat_nxt = beat_q + 1'b1;

  always_comb begin
    if (adv) begin
      cyc_op   = op_q;
      cyc_addr = {base_q[ADDR_W-1:BURST_BITS],
                  burst_low(base_q[BURST_BITS-1:0], beat_nxt, linear_order)};
    end else begin
      cyc_op   = !selected ? OP_IDLE : (wr ? OP_WRITE : OP_READ);
      cyc_addr = addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
      op_q   <= OP_IDLE;
    end else if (step) begin
      if (adv) begin
        beat_q <= beat_nxt;
      end else begin
        base_q <= addr;
        beat_q <= '0;
        op_q   <= cyc_op;
      end
    end
  end
endmodule

// File: rtl/nts_array.sv
module nts_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_be,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] stored;
  logic              hit;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_be[l]) mem[wr_addr][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
      end
    end
  end

  assign stored = mem[rd_addr];
  assign hit    = wr_en && (wr_addr == rd_addr);

  // Per-lane forwarding of a write committing in the same edge.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign rd_data[l*LANE_W +: LANE_W] = (hit && wr_be[l]) ?
      wr_data[l*LANE_W +: LANE_W] : stored[l*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/nts_out.sv
module nts_out #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              oe,
  input  logic              sleep,
  output logic [DATA_W-1:0] q,
  output logic              q_en
);
  logic [DATA_W-1:0] q_r;
  logic              valid_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r     <= '0;
      valid_r <= 1'b0;
    end else if (step) begin
      valid_r <= load;
      if (load) q_r <= din;
    end
  end

  assign q_en = valid_r && oe && !sleep;
  assign q    = q_en ? q_r : '0;
endmodule

// File: rtl/nt_sram.sv
module nt_sram
  import nts_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cken,
  input  logic              sel_a,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              wr,
  input  logic              adv,
  input  logic [LANES-1:0]  byte_we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              linear_order,
  input  logic              oe,
  input  logic              sleep,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_en
);
  logic              step;
  logic              selected;
  op_e               cyc_op;
  logic [ADDR_W-1:0] cyc_addr;
  op_e               s1_op, s2_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [LANES-1:0]  s1_be, s2_be;
  logic              commit;
  logic [DATA_W-1:0] arr_q;

  assign step     = cken && !sleep;
  assign selected = sel_a && sel_b && !sel_c_n;

  nts_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .step(step), .selected(selected),
    .adv(adv), .wr(wr), .addr(addr), .linear_order(linear_order),
    .cyc_op(cyc_op), .cyc_addr(cyc_addr)
  );

  // Stage 1: command just captured; stage 2: write awaiting its data.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op   <= OP_IDLE;
      s1_addr <= '0;
      s1_be   <= '0;
      s2_op   <= OP_IDLE;
      s2_addr <= '0;
      s2_be   <= '0;
    end else if (step) begin
      s1_op   <= cyc_op;
      s1_addr <= cyc_addr;
      s1_be   <= byte_we;
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
    end
  end

  assign commit = step && (s2_op == OP_WRITE);

  nts_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .wr_en(commit), .wr_addr(s2_addr), .wr_be(s2_be),
    .wr_data(wdata), .rd_addr(s1_addr), .rd_data(arr_q)
  );

  nts_out #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .step(step), .load(s1_op == OP_READ),
    .din(arr_q), .oe(oe), .sleep(sleep), .q(rdata), .q_en(rdata_en)
  );
endmodule

// File: rtl/nts_chk.sv
module nts_chk
  import nts_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cken,
  input logic              sleep,
  input logic              oe,
  input logic              adv,
  input logic              step,
  input logic              rdata_en,
  input logic [DATA_W-1:0] rdata,
  input op_e               s1_op,
  input op_e               s2_op,
  input logic [ADDR_W-1:0] s1_addr
);
  // R9
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (!rdata_en && rdata == '0));

  // R8
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (!rdata_en && rdata == '0));

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cken |=> ($stable(s1_op) && $stable(s2_op) && $stable(s1_addr)));

  // R6
  burst_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && adv) |=> (s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2])));

  // R1
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && s1_op == OP_READ) |=> (rdata_en || !oe || sleep));

  // R2
  write_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && s1_op == OP_WRITE) |=> (s2_op == OP_WRITE));
endmodule

bind nt_sram nts_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cken(cken), .sleep(sleep), .oe(oe), .adv(adv),
  .step(step), .rdata_en(rdata_en), .rdata(rdata), .s1_op(s1_op),
  .s2_op(s2_op), .s1_addr(s1_addr)
);

// File: tb/tb_nt_sram.sv
module tb_nt_sram;
  localparam logic [2:0] SEL = 3'b110;  // {sel_a, sel_b, sel_c_n}

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cken = 1'b1, sel_a = 1'b0, sel_b = 1'b0, sel_c_n = 1'b1;
  logic        wr = 1'b0, adv = 1'b0, linear_order = 1'b1, oe = 1'b1, sleep = 1'b0;
  logic [1:0]  byte_we = '0;
  logic [5:0]  addr = '0;
  logic [17:0] wdata = '0;
  logic [17:0] rdata;
  logic        rdata_en;

  int checks = 0, fails = 0;
  logic done = 1'b0;

  // Bench model
  logic [17:0] ref_mem [64];
  int          p_op [2];   // 0 idle, 1 read, 2 write; [0] newest
  logic [5:0]  p_addr [2];
  logic [1:0]  p_be [2];
  logic [17:0] p_dat [2];
  logic        m_valid = 1'b0;
  logic [17:0] m_q = '0;
  int          b_op = 0;
  logic [5:0]  b_base = '0;
  logic [1:0]  b_cnt = '0;

  always #5 clk = ~clk;

  nt_sram dut (
    .clk(clk), .rst_n(rst_n), .cken(cken), .sel_a(sel_a), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .wr(wr), .adv(adv), .byte_we(byte_we), .addr(addr),
    .wdata(wdata), .linear_order(linear_order), .oe(oe), .sleep(sleep),
    .rdata(rdata), .rdata_en(rdata_en)
  );

  function automatic logic [17:0] dat(input int a, input int k);
    return 18'((a * 2654435 + k * 40503 + 17) & 32'h3FFFF);
  endfunction

  task automatic check_out(input string tag);
    logic        e_en;
    logic [17:0] e_q;
    e_en = m_valid && oe && !sleep;
    e_q  = e_en ? m_q : 18'h0;
    checks++;
    if (rdata_en !== e_en || rdata !== e_q) begin
      fails++;
      $display("FAIL %s: rdata_en=%0b rdata=%h expected rdata_en=%0b rdata=%h",
               tag, rdata_en, rdata, e_en, e_q);
    end
  endtask

  task automatic tick(input string tag, input logic [2:0] cs, input logic w,
                      input logic a_adv, input logic [5:0] a, input logic [1:0] be,
                      input logic [17:0] d);
    logic       en;
    int         nop;
    logic [5:0] naddr;
    en = cken && !sleep;
    {sel_a, sel_b, sel_c_n} = cs;
    wr = w; adv = a_adv; addr = a; byte_we = be;
    if (p_op[1] == 2) wdata = en ? p_dat[1] : ~p_dat[1];
    else              wdata = 18'h2A5A5;
    nop = 0; naddr = '0;
    if (en) begin
      if (!a_adv) begin
        nop = (cs == SEL) ? (w ? 2 : 1) : 0;
        naddr = a; b_base = a; b_cnt = 2'd0; b_op = nop;
      end else begin
        b_cnt = b_cnt + 2'd1;
        nop = b_op;
        naddr = {b_base[5:2], linear_order ? (b_base[1:0] + b_cnt) : (b_base[1:0] ^ b_cnt)};
      end
    end
    @(posedge clk); #1;
    if (en) begin
      if (p_op[1] == 2) begin
        if (p_be[1][0]) ref_mem[p_addr[1]][8:0]  = p_dat[1][8:0];
        if (p_be[1][1]) ref_mem[p_addr[1]][17:9] = p_dat[1][17:9];
      end
      m_valid = (p_op[0] == 1);
      if (m_valid) m_q = ref_mem[p_addr[0]];
      p_op[1] = p_op[0]; p_addr[1] = p_addr[0]; p_be[1] = p_be[0]; p_dat[1] = p_dat[0];
      p_op[0] = nop; p_addr[0] = naddr; p_be[0] = be; p_dat[0] = d;
    end
    check_out(tag);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) tick(tag, 3'b000, 1'b0, 1'b0, 6'd0, 2'b00, 18'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin p_op[i] = 0; p_addr[i] = '0; p_be[i] = '0; p_dat[i] = '0; end
    repeat (3) @(posedge clk);
    #1;
    check_out("R11 reset");
    rst_n = 1'b1;
    idle("R11 idle after reset", 2);

    // R2: fill every word with back-to-back writes
    for (int a = 0; a < 64; a++) tick("R2 write fill", SEL, 1'b1, 1'b0, 6'(a), 2'b11, dat(a, 0));
    idle("R2 drain", 2);
    // R1: back-to-back reads of every word
    for (int a = 0; a < 64; a++) tick("R1 read sweep", SEL, 1'b0, 1'b0, 6'(a), 2'b00, 18'h0);
    idle("R1 drain", 2);
    // R12: alternate write and read every cycle
    for (int a = 0; a < 64; a++) begin
      tick("R12 alternate write", SEL, 1'b1, 1'b0, 6'(a), 2'b11, dat(a, 1));
      tick("R12 alternate read", SEL, 1'b0, 1'b0, 6'((a + 32) % 64), 2'b00, 18'h0);
    end
    idle("R12 drain", 2);
    // R10 / R3: read right behind a write, for every byte-enable pattern
    for (int be = 0; be < 4; be++) begin
      for (int a = 0; a < 8; a++) begin
        tick("R10 write", SEL, 1'b1, 1'b0, 6'(a), 2'(be), dat(a, be + 2));
        tick("R10 bypass read", SEL, 1'b0, 1'b0, 6'(a), 2'b00, 18'h0);
        idle("R10 gap", 1);
        tick("R3 lane read", SEL, 1'b0, 1'b0, 6'(a), 2'b00, 18'h0);
      end
    end
    idle("R3 drain", 2);

    // R4: stalls while write data pending and while output valid
    tick("R4 write", SEL, 1'b1, 1'b0, 6'd5, 2'b11, dat(5, 20));
    cken = 1'b0;
    for (int i = 0; i < 3; i++) tick("R4 stalled cmd ignored", SEL, 1'b1, 1'b0, 6'd9, 2'b11, dat(9, 21));
    cken = 1'b1;
    tick("R4 resume read", SEL, 1'b0, 1'b0, 6'd5, 2'b00, 18'h0);
    tick("R4 read 9", SEL, 1'b0, 1'b0, 6'd9, 2'b00, 18'h0);
    cken = 1'b0;
    for (int i = 0; i < 3; i++) tick("R4 output hold", SEL, 1'b0, 1'b0, 6'd1, 2'b00, 18'h0);
    cken = 1'b1;
    idle("R4 drain", 3);

    // R5: every non-selecting combination is a deselect
    for (int cs = 0; cs < 8; cs++) begin
      if (cs != 6) begin
        tick("R5 deselect write", 3'(cs), 1'b1, 1'b0, 6'd10, 2'b11, dat(10, 30 + cs));
        tick("R5 deselect read", 3'(cs), 1'b0, 1'b0, 6'd10, 2'b00, 18'h0);
      end
    end
    idle("R5 drain", 2);
    tick("R5 read back", SEL, 1'b0, 1'b0, 6'd10, 2'b00, 18'h0);
    idle("R5 drain", 2);

    // R6 / R7: bursts for both orders and every seed, five beats (wrap)
    for (int lin = 0; lin < 2; lin++) begin
      linear_order = lin[0];
      for (int s = 0; s < 4; s++) begin
        tick("R7 burst write load", SEL, 1'b1, 1'b0, 6'(40 + s), 2'b11, dat(s, 40 + lin));
        for (int n = 1; n < 5; n++)
          tick("R6 burst write advance", 3'b000, 1'b0, 1'b1, 6'd0, 2'(n), dat(s * 8 + n, 50 + lin));
        idle("R7 gap", 1);
        tick("R7 burst read load", SEL, 1'b0, 1'b0, 6'(16 + s), 2'b00, 18'h0);
        for (int n = 1; n < 5; n++)
          tick("R7 burst read advance", 3'b001, 1'b1, 1'b1, 6'd63, 2'b11, 18'h0);
        tick("R7 burst read back load", SEL, 1'b0, 1'b0, 6'(40 + s), 2'b00, 18'h0);
        for (int n = 1; n < 4; n++)
          tick("R7 burst read back advance", SEL, 1'b0, 1'b1, 6'd0, 2'b00, 18'h0);
        idle("R7 drain", 2);
      end
    end
    // R6: advance after a deselect stays deselected
    tick("R6 deselect load", 3'b000, 1'b1, 1'b0, 6'd20, 2'b11, 18'h0);
    tick("R6 advance no write", SEL, 1'b1, 1'b1, 6'd20, 2'b11, dat(20, 60));
    tick("R6 advance no write", SEL, 1'b1, 1'b1, 6'd20, 2'b11, dat(21, 60));
    idle("R6 drain", 2);
    for (int a = 20; a < 24; a++) tick("R6 read unchanged", SEL, 1'b0, 1'b0, 6'(a), 2'b00, 18'h0);
    idle("R6 drain", 2);

    // R8: asynchronous output enable
    tick("R8 read", SEL, 1'b0, 1'b0, 6'd3, 2'b00, 18'h0);
    idle("R8 valid", 1);
    oe = 1'b0; #1; check_out("R8 oe low off");
    tick("R8 pipeline runs", SEL, 1'b0, 1'b0, 6'd4, 2'b00, 18'h0);
    idle("R8 oe low", 1);
    oe = 1'b1; #1; check_out("R8 oe restored");

    // R9: sleep turns outputs off and ignores edges
    sleep = 1'b1; #1; check_out("R9 sleep off");
    tick("R9 ignored write", SEL, 1'b1, 1'b0, 6'd11, 2'b11, dat(11, 70));
    tick("R9 ignored", 3'b000, 1'b0, 1'b0, 6'd0, 2'b00, 18'h0);
    sleep = 1'b0; #1; check_out("R9 wake output");
    idle("R9 drain", 2);
    tick("R9 read unchanged", SEL, 1'b0, 1'b0, 6'd11, 2'b00, 18'h0);
    idle("R9 drain", 2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule